// File: doc/BRIEF.md
# Nested Residue Modular Multiplier

This block multiplies two unsigned binary operands inside a two-level residue number system. The outer level represents each operand by its remainders modulo 7, 11 and 13, which together span 1001 values. The remainder modulo 7 already fits in three bits and is kept as it is. The remainders modulo 11 and modulo 13 need four bits, so each is split again into a tuple of remainders modulo 5, 6 and 7. As a result, every channel multiplier in the datapath works on three-bit values only.

Each operand pair moves through four registered stages. The first converts both operands to the nested form. The second multiplies channel by channel. The third folds each inner tuple back to its outer remainder, using the Chinese remainder theorem over 210 and then reducing by 11 or 13. The fourth rebuilds the binary product from the three outer remainders, using the Chinese remainder theorem over 1001. The block accepts a new operand pair on every clock. Operand pairs whose product is 1001 or more are outside its range.

Top module: `nrns_mult`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for the cycle that follows the fourth rising edge, counting that sampling edge as the first. A new operand pair can be accepted on every clock, so back-to-back inputs produce back-to-back results.
- R2: With `out_valid` high, `res_m7` equals the true product modulo 7 and lies in 0..6.
- R3: With `out_valid` high, `res_m11` equals the true product modulo 11 and lies in 0..10. This value is obtained by multiplying over the inner moduli 5, 6 and 7 and folding the result.
- R4: With `out_valid` high, `res_m13` equals the true product modulo 13 and lies in 0..12. This value is also obtained through the inner moduli 5, 6 and 7.
- R5: With `out_valid` high, `product` equals `op_a * op_b` for every operand pair whose product is below 1001. The sum of the reconstruction weights 715, 364 and 924 is reduced modulo 1001.
- R6: The operands 19 and 22 give outer remainders (5, 0, 2) and the product 418.
- R7: A synchronous active-high `rst` clears `out_valid`, `product` and all three remainder outputs to zero. It also discards any results still in the pipeline.
- R8: A cycle with `in_valid` low gives `out_valid` low four edges later. While `out_valid` is low, `product` and the remainder outputs keep the last result.
- R9: Boundary operands give exact results. These include a zero operand, a product of exactly 1000, and operands whose remainder modulo 13 is 12, where the inner product reaches its largest value, 144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| op_a | input | OPW (10) | First unsigned operand |
| op_b | input | OPW (10) | Second unsigned operand |
| out_valid | output | 1 | Result outputs are valid this cycle |
| product | output | 10 | Binary product rebuilt from the outer remainders |
| res_m7 | output | 3 | Product remainder modulo 7 |
| res_m11 | output | 4 | Product remainder modulo 11 |
| res_m13 | output | 4 | Product remainder modulo 13 |

## Verification
A table of operand pairs is streamed back to back, so the latency and per-cycle throughput are checked at the same time as the arithmetic.

The table holds several kinds of pairs, and each exposes a different fault:
- The worked pair 19 × 22 pins down the full chain of conversion and folding.
- Zero and one operands expose constant offsets in the weights.
- Pairs whose remainder modulo 13 is 12 drive the inner channels to their maximum product, which exposes truncated fold arithmetic.
- Products at 1000, 999 and 992 sit near the top of the range, where a wrong final reduction appears.

After the stream, idle cycles check that the outputs hold their last value. A reset is then applied while results are still in flight, and the cleared outputs are checked.

// File: rtl/nrns_pkg.sv
package nrns_pkg;

    // Outer and inner moduli, fixed by the number system
    localparam int OUT_M0   = 7;
    localparam int OUT_M1   = 11;
    localparam int OUT_M2   = 13;
    localparam int OUT_RANGE = OUT_M0 * OUT_M1 * OUT_M2;   // 1001
    localparam int IN_M0    = 5;
    localparam int IN_M1    = 6;
    localparam int IN_M2    = 7;
    localparam int IN_RANGE = IN_M0 * IN_M1 * IN_M2;       // 210

    localparam int RES_W   = 3;
    localparam int OUTER_W = 4;
    localparam int PROD_W  = $clog2(OUT_RANGE);

    // CRT weights: inner set over 210, outer set over 1001
    localparam int IW0 = 126;
    localparam int IW1 = 175;
    localparam int IW2 = 120;
    localparam int OW0 = 715;
    localparam int OW1 = 364;
    localparam int OW2 = 924;

    typedef logic [RES_W-1:0] res_t;

    typedef struct packed {
        res_t m5;
        res_t m6;
        res_t m7;
    } inner_t;

    typedef struct packed {
        res_t   r7;
        inner_t n11;
        inner_t n13;
    } nested_t;

    typedef struct packed {
        logic [RES_W-1:0]   r7;
        logic [OUTER_W-1:0] r11;
        logic [OUTER_W-1:0] r13;
    } outer_t;

    function automatic inner_t split_inner(input int v);
        inner_t t;
        t.m5 = RES_W'(v % IN_M0);
        t.m6 = RES_W'(v % IN_M1);
        t.m7 = RES_W'(v % IN_M2);
        return t;
    endfunction

    function automatic res_t mul_mod(input res_t a, input res_t b, input int m);
        return RES_W'((int'(a) * int'(b)) % m);
    endfunction

    function automatic inner_t mul_inner(input inner_t a, input inner_t b);
        inner_t p;
        p.m5 = mul_mod(a.m5, b.m5, IN_M0);
        p.m6 = mul_mod(a.m6, b.m6, IN_M1);
        p.m7 = mul_mod(a.m7, b.m7, IN_M2);
        return p;
    endfunction

    function automatic logic [OUTER_W-1:0] fold_inner(input inner_t t, input int m);
        int s;
        s = int'(t.m5) * IW0 + int'(t.m6) * IW1 + int'(t.m7) * IW2;
        s = s % IN_RANGE;
        return OUTER_W'(s % m);
    endfunction

    function automatic logic [PROD_W-1:0] rebuild(input outer_t r);
        int s;
        s = int'(r.r7) * OW0 + int'(r.r11) * OW1 + int'(r.r13) * OW2;
        return PROD_W'(s % OUT_RANGE);
    endfunction

endpackage

// File: rtl/nrns_fwd_conv.sv
module nrns_fwd_conv
    import nrns_pkg::*;
#(
    parameter int OPW = 10
) (
    input  logic [OPW-1:0] x,
    output nested_t        y
);
    int v;
    always_comb begin
        v     = int'(x);
        y.r7  = RES_W'(v % OUT_M0);
        y.n11 = split_inner(v % OUT_M1);
        y.n13 = split_inner(v % OUT_M2);
    end
endmodule

// File: rtl/nrns_chan_mul.sv
module nrns_chan_mul
    import nrns_pkg::*;
(
    input  nested_t a,
    input  nested_t b,
    output nested_t p
);
    always_comb begin
        p.r7  = mul_mod(a.r7, b.r7, OUT_M0);
        p.n11 = mul_inner(a.n11, b.n11);
        p.n13 = mul_inner(a.n13, b.n13);
    end
endmodule

// File: rtl/nrns_fold.sv
module nrns_fold
    import nrns_pkg::*;
(
    input  nested_t n,
    output outer_t  o
);
    always_comb begin
        o.r7  = n.r7;
        o.r11 = fold_inner(n.n11, OUT_M1);
        o.r13 = fold_inner(n.n13, OUT_M2);
    end
endmodule

// File: rtl/nrns_crt_recon.sv
module nrns_crt_recon
    import nrns_pkg::*;
(
    input  outer_t              r,
    output logic [PROD_W-1:0]   x
);
    always_comb x = rebuild(r);
endmodule

// File: rtl/nrns_mult.sv
module nrns_mult
    import nrns_pkg::*;
#(
    parameter int OPW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OPW-1:0]       op_a,
    input  logic [OPW-1:0]       op_b,
    output logic                 out_valid,
    output logic [PROD_W-1:0]    product,
    output logic [RES_W-1:0]     res_m7,
    output logic [OUTER_W-1:0]   res_m11,
    output logic [OUTER_W-1:0]   res_m13
);
    localparam int NOPS = 2;

    logic [OPW-1:0] ops [NOPS];
    nested_t        conv [NOPS];
    nested_t        s1_n [NOPS];
    nested_t        mul_c, s2_p;
    outer_t         fold_c, s3_o, s4_o;
    logic [PROD_W-1:0] rec_c, s4_x;
    logic v1, v2, v3, v4;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // Stage 1: one forward converter per operand
    for (genvar g = 0; g < NOPS; g++) begin : g_conv
        nrns_fwd_conv #(.OPW(OPW)) u_conv (.x(ops[g]), .y(conv[g]));

        always_ff @(posedge clk) begin
            if (rst)           s1_n[g] <= '0;
            else if (in_valid) s1_n[g] <= conv[g];
        end
    end

    nrns_chan_mul  u_mul  (.a(s1_n[0]), .b(s1_n[1]), .p(mul_c));
    nrns_fold      u_fold (.n(s2_p), .o(fold_c));
    nrns_crt_recon u_rec  (.r(s3_o), .x(rec_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            v2   <= 1'b0;
            v3   <= 1'b0;
            v4   <= 1'b0;
            s2_p <= '0;
            s3_o <= '0;
            s4_o <= '0;
            s4_x <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
            v4 <= v3;
            if (v1) s2_p <= mul_c;
            if (v2) s3_o <= fold_c;
            if (v3) begin
                s4_o <= s3_o;
                s4_x <= rec_c;
            end
        end
    end

    assign out_valid = v4;
    assign product   = s4_x;
    assign res_m7    = s4_o.r7;
    assign res_m11   = s4_o.r11;
    assign res_m13   = s4_o.r13;
endmodule

// File: rtl/nrns_mult_chk.sv
module nrns_mult_chk
    import nrns_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [PROD_W-1:0]    product,
    input logic [RES_W-1:0]     res_m7,
    input logic [OUTER_W-1:0]   res_m11,
    input logic [OUTER_W-1:0]   res_m13
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 out_valid);

    assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##4 !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(product) && $stable(res_m7)
                        && $stable(res_m11) && $stable(res_m13)));

    assert_m7_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_m7 < 3'd7 && (product % 7) == res_m7));

    assert_m11_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_m11 < 4'd11 && (product % 11) == res_m11));

    assert_m13_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_m13 < 4'd13 && (product % 13) == res_m13));

    assert_range_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> product < PROD_W'(OUT_RANGE));
endmodule

bind nrns_mult nrns_mult_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .product(product), .res_m7(res_m7), .res_m11(res_m11), .res_m13(res_m13)
);

// File: tb/sim_nrns_mult.sv
module sim_nrns_mult;
    localparam int OPW = 10;
    localparam int NV  = 16;
    localparam int LAT = 4;

    // R6 first, then R9 boundaries, then general pairs
    localparam int VA [NV] = '{19, 0, 1, 8, 12, 25, 3, 31, 12, 90, 143, 6, 7, 13, 1, 38};
    localparam int VB [NV] = '{22, 777, 1, 125, 12, 40, 333, 32, 83, 11, 6, 9, 11, 76, 1000, 25};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [OPW-1:0] op_a = '0, op_b = '0;
    logic out_valid;
    logic [9:0] product;
    logic [2:0] res_m7;
    logic [3:0] res_m11, res_m13;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nrns_mult #(.OPW(OPW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product), .res_m7(res_m7),
        .res_m11(res_m11), .res_m13(res_m13)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_result(input int p);
        chk("R1 out_valid", int'(out_valid), 1);
        chk("R2 res_m7", int'(res_m7), p % 7);
        chk("R3 res_m11", int'(res_m11), p % 11);
        chk("R4 res_m13", int'(res_m13), p % 13);
        chk("R5 product", int'(product), p);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int last_p;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 out_valid", int'(out_valid), 0);
        chk("R7 product", int'(product), 0);
        chk("R7 residues", int'(res_m7) + int'(res_m11) + int'(res_m13), 0);
        rst = 1'b0;

        // Stream table back to back; check each result LAT negedges later
        last_p = 0;
        for (int j = 0; j < NV + LAT + 3; j++) begin
            @(negedge clk);
            if (j - LAT >= 0 && j - LAT < NV) begin
                last_p = VA[j-LAT] * VB[j-LAT];
                chk_result(last_p);
                if (j - LAT == 0) begin
                    // R6 worked pair 19 x 22
                    chk("R6 res_m7", int'(res_m7), 5);
                    chk("R6 res_m11", int'(res_m11), 0);
                    chk("R6 res_m13", int'(res_m13), 2);
                    chk("R6 product", int'(product), 418);
                end
            end else if (j - LAT >= NV) begin
                // R8: idle cycles keep the last result
                chk("R8 out_valid low", int'(out_valid), 0);
                chk("R8 product held", int'(product), last_p);
            end
            if (j < NV) begin
                in_valid = 1'b1;
                op_a = OPW'(VA[j]);
                op_b = OPW'(VB[j]);
            end else begin
                in_valid = 1'b0;
            end
        end

        // R8 bubble: valid, gap, valid gives valid, gap, valid
        @(negedge clk); in_valid = 1'b1; op_a = 10'd12; op_b = 10'd12;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); in_valid = 1'b1; op_a = 10'd0;  op_b = 10'd999;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_result(144);                       // R9 largest inner product
        @(negedge clk);
        chk("R8 bubble low", int'(out_valid), 0);
        chk("R8 bubble hold", int'(product), 144);
        @(negedge clk);
        chk_result(0);                         // R9 zero operand

        // R7: reset with results in flight
        in_valid = 1'b1; op_a = 10'd31; op_b = 10'd32;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R7 flush valid", int'(out_valid), 0);
        chk("R7 flush product", int'(product), 0);
        repeat (4) begin
            @(negedge clk);
            chk("R7 no stale result", int'(out_valid), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule